// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block turns a process identifier and a virtual address into a physical address by searching a table that holds one entry per physical frame. Each entry is either free or names the process and virtual page that occupy its frame, so the physical frame number is simply the index of the entry that matches. Pages are 4 KB. The twelve low address bits therefore pass through unchanged, and only the virtual page number takes part in the search.

The search starts at a hashed index and walks forward one entry per clock cycle, wrapping at the end of the table. It stops at a matching entry, at a free entry, or after every frame has been visited. A requester treats a miss as a page fault. A second port maintains the table. An insert claims the first free entry along the same probe path as a lookup. A free command releases one frame by its index. While an insert is running, no lookup is accepted.

Top module: `ipt_lookup`

## Requirements
- R1: After reset every entry is free, both ready outputs are high, and no response or command completion is pending.
- R2: The low 12 bits of `resp_paddr` equal the low 12 bits of the request's `req_vaddr`, on hits and on misses. On a miss the frame field is zero.
- R3: On a hit, `resp_hit` is 1 and `resp_paddr[14:12]` is the index of the entry whose process ID and virtual page number both equal the request.
- R4: Probing starts at index `vpn[2:0] ^ pid[2:0]`, where vpn is `req_vaddr[21:12]`. An insert into a free home slot lands there.
- R5: Each further probe goes to the next index, and index 7 wraps to 0. This applies to inserts and to lookups.
- R6: A lookup that reaches a free entry ends as a miss, even if a matching entry lies further along the ring.
- R7: A lookup ends as a miss after 8 probes when no entry matched and none was free. An insert into a full table completes with `cmd_ok` = 0.
- R8: `resp_valid` is a one-cycle pulse. It appears exactly N cycles after the cycle in which the request was accepted, where N is the number of probes made.
- R9: A free command (`cmd_free` = 1) makes entry `cmd_frame` free. One cycle later `cmd_done` pulses with `cmd_ok` equal to whether that entry had been occupied. Afterwards a lookup of its former key misses.
- R10: When a command and a request arrive together, the command wins and `req_ready` is low. During an insert, both `req_ready` and `cmd_ready` stay low.
- R11: An entry matches only if both fields agree. An entry with the same virtual page but a different process ID is probed past.
- R12: A successful insert reports `cmd_ok` = 1 and returns in `cmd_slot` the frame index it occupied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_pid | input | 6 | Requesting process ID |
| req_vaddr | input | 22 | Virtual address (page number and offset) |
| resp_valid | output | 1 | Lookup result pulse |
| resp_hit | output | 1 | 1 on a hit, 0 on a page fault |
| resp_paddr | output | 15 | Frame index and offset |
| cmd_valid | input | 1 | Table command present |
| cmd_ready | output | 1 | Table command can be accepted |
| cmd_free | input | 1 | 1 = free a frame, 0 = insert |
| cmd_pid | input | 6 | Process ID to insert |
| cmd_vpn | input | 10 | Virtual page number to insert |
| cmd_frame | input | 3 | Frame to release on a free |
| cmd_done | output | 1 | Command completion pulse |
| cmd_ok | output | 1 | Insert placed, or freed entry was occupied |
| cmd_slot | output | 3 | Frame inserted into, or frame freed |

## Verification
The bench uses the default parameters: a 3-bit frame index, which gives 8 frames, a 6-bit process ID and a 10-bit virtual page number. With only eight frames, a few inserts are enough to build a collision chain through the wrap from index 7 to 0, to break a chain by freeing its head, and to fill the whole table. That brings the full 8-probe miss and the failed insert within reach. A bench reference model predicts each result and its probe count, so the latency is checked against the number of probes and not against a fixed figure.

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int PID_W = 6,
  parameter int VPN_W = 10,
  parameter int OFF_W = 12,
  parameter int FW    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PID_W-1:0]   req_pid,
  input  logic [VPN_W+OFF_W-1:0] req_vaddr,
  output logic               resp_valid,
  output logic               resp_hit,
  output logic [FW+OFF_W-1:0] resp_paddr,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_free,
  input  logic [PID_W-1:0]   cmd_pid,
  input  logic [VPN_W-1:0]   cmd_vpn,
  input  logic [FW-1:0]      cmd_frame,
  output logic               cmd_done,
  output logic               cmd_ok,
  output logic [FW-1:0]      cmd_slot
);
  localparam int FRAMES = 1 << FW;
  localparam int VA_W   = VPN_W + OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_INS} st_t;
  st_t state;

  logic             tv   [FRAMES];
  logic [PID_W-1:0] tpid [FRAMES];
  logic [VPN_W-1:0] tvpn [FRAMES];

  logic [PID_W-1:0] k_pid;
  logic [VPN_W-1:0] k_vpn;
  logic [OFF_W-1:0] k_off;
  logic [FW-1:0]    ptr, cnt;

  function automatic logic [FW-1:0] home(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v);
    return v[FW-1:0] ^ p[FW-1:0];
  endfunction

  wire match = tv[ptr] && tpid[ptr] == k_pid && tvpn[ptr] == k_vpn;
  wire last  = cnt == FW'(FRAMES - 1);

  assign cmd_ready = state == S_IDLE;
  assign req_ready = state == S_IDLE && !cmd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_paddr <= '0;
      cmd_done   <= 1'b0;
      cmd_ok     <= 1'b0;
      cmd_slot   <= '0;
      k_pid      <= '0;
      k_vpn      <= '0;
      k_off      <= '0;
      ptr        <= '0;
      cnt        <= '0;
      for (int i = 0; i < FRAMES; i++) begin
        tv[i]   <= 1'b0;
        tpid[i] <= '0;
        tvpn[i] <= '0;
      end
    end else begin
      resp_valid <= 1'b0;
      cmd_done   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            if (cmd_free) begin
              cmd_done      <= 1'b1;
              cmd_ok        <= tv[cmd_frame];
              cmd_slot      <= cmd_frame;
              tv[cmd_frame] <= 1'b0;
            end else begin
              k_pid <= cmd_pid;
              k_vpn <= cmd_vpn;
              ptr   <= home(cmd_pid, cmd_vpn);
              cnt   <= '0;
              state <= S_INS;
            end
          end else if (req_valid) begin
            k_pid <= req_pid;
            k_vpn <= req_vaddr[VA_W-1:OFF_W];
            k_off <= req_vaddr[OFF_W-1:0];
            ptr   <= home(req_pid, req_vaddr[VA_W-1:OFF_W]);
            cnt   <= '0;
            state <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (match) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_paddr <= {ptr, k_off};
            state      <= S_IDLE;
          end else if (!tv[ptr] || last) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            resp_paddr <= {{FW{1'b0}}, k_off};
            state      <= S_IDLE;
          end else begin
            ptr <= ptr + 1'b1;
            cnt <= cnt + 1'b1;
          end
        end
        S_INS: begin
          if (!tv[ptr]) begin
            tv[ptr]   <= 1'b1;
            tpid[ptr] <= k_pid;
            tvpn[ptr] <= k_vpn;
            cmd_done  <= 1'b1;
            cmd_ok    <= 1'b1;
            cmd_slot  <= ptr;
            state     <= S_IDLE;
          end else if (last) begin
            cmd_done <= 1'b1;
            cmd_ok   <= 1'b0;
            cmd_slot <= ptr;
            state    <= S_IDLE;
          end else begin
            ptr <= ptr + 1'b1;
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int VA_W  = 22,
  parameter int PA_W  = 15,
  parameter int OFF_W = 12,
  parameter int FW    = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            resp_valid,
  input logic [PA_W-1:0] resp_paddr,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic            cmd_free,
  input logic            cmd_done
);
  localparam int FRAMES = 1 << FW;

  logic             busy;
  logic [FW+1:0]    lat;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      lat   <= '0;
      off_q <= '0;
    end else if (req_valid && req_ready) begin
      busy  <= 1'b1;
      lat   <= 1;
      off_q <= req_vaddr[OFF_W-1:0];
    end else if (resp_valid) begin
      busy <= 1'b0;
    end else if (busy) begin
      lat <= lat + 1'b1;
    end
  end

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_paddr[OFF_W-1:0] == off_q);

  a_r7_probe_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> lat <= (FW+2)'(FRAMES + 1));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  a_r8_not_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !resp_valid);

  a_r10_insert_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_free) |=> (!req_ready && !cmd_ready));

  a_r10_exclusive_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid && cmd_done));
endmodule

bind ipt_lookup ipt_lookup_chk #(
  .VA_W(VPN_W + OFF_W), .PA_W(FW + OFF_W), .OFF_W(OFF_W), .FW(FW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_free(cmd_free),
  .cmd_done(cmd_done)
);

// File: tb/sim_ipt_lookup.sv
module sim_ipt_lookup;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_ready;
  logic [5:0]  req_pid = 0;
  logic [21:0] req_vaddr = 0;
  logic        resp_valid, resp_hit;
  logic [14:0] resp_paddr;
  logic        cmd_valid = 0, cmd_ready, cmd_free = 0;
  logic [5:0]  cmd_pid = 0;
  logic [9:0]  cmd_vpn = 0;
  logic [2:0]  cmd_frame = 0;
  logic        cmd_done, cmd_ok;
  logic [2:0]  cmd_slot;

  ipt_lookup u0 (.*);

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic       m_v [8];
  logic [5:0] m_p [8];
  logic [9:0] m_n [8];

  bit      q_hit[$];
  bit [14:0] q_pa[$];
  int      q_pr[$];
  int      acc;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (resp_valid) begin
    if (q_hit.size() == 0) chk(0, "R8", "unexpected response", 1, 0);
    else begin
      automatic bit h = q_hit.pop_front();
      automatic bit [14:0] pa = q_pa.pop_front();
      automatic int pr = q_pr.pop_front();
      chk(resp_hit == h, "R3", "hit", resp_hit, h);
      chk(resp_paddr == pa, "R2", "paddr", resp_paddr, pa);
      chk(cyc - acc == pr, "R8", "latency", cyc - acc, pr);
    end
  end

  task automatic lookup(input logic [5:0] pid, input logic [9:0] vpn, input logic [11:0] off);
    automatic int idx = (vpn[2:0] ^ pid[2:0]);
    automatic bit h = 0;
    automatic int fr = 0, pr = 0;
    for (int k = 0; k < 8; k++) begin
      pr = k + 1;
      if (m_v[idx] && m_p[idx] == pid && m_n[idx] == vpn) begin h = 1; fr = idx; break; end
      if (!m_v[idx]) break;
      idx = (idx + 1) % 8;
    end
    q_hit.push_back(h);
    q_pa.push_back({3'(fr), off});
    q_pr.push_back(pr);
    req_valid = 1; req_pid = pid; req_vaddr = {vpn, off};
    acc = cyc + 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    for (int w = 0; w < 20 && q_hit.size() != 0; w++) @(negedge clk);
    if (q_hit.size() != 0) begin chk(0, "R8", "no response", 0, 1); q_hit.delete(); q_pa.delete(); q_pr.delete(); end
  endtask

  task automatic insert(input logic [5:0] pid, input logic [9:0] vpn, input string req);
    automatic int idx = (vpn[2:0] ^ pid[2:0]);
    automatic bit ok = 0;
    automatic int slot = 0;
    for (int k = 0; k < 8; k++) begin
      if (!m_v[idx]) begin ok = 1; slot = idx; break; end
      idx = (idx + 1) % 8;
    end
    cmd_valid = 1; cmd_free = 0; cmd_pid = pid; cmd_vpn = vpn;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
    chk(!req_ready && !cmd_ready, "R10", "busy during insert", {req_ready, cmd_ready}, 0);
    for (int w = 0; w < 20 && !cmd_done; w++) @(negedge clk);
    chk(cmd_done && cmd_ok == ok, req, "insert ok", cmd_ok, ok);
    if (ok) begin
      chk(cmd_slot == 3'(slot), req, "insert slot", cmd_slot, slot);
      m_v[slot] = 1; m_p[slot] = pid; m_n[slot] = vpn;
    end
    @(negedge clk);
  endtask

  task automatic free_frame(input logic [2:0] fr, input bit with_req);
    automatic bit exp = m_v[fr];
    cmd_valid = 1; cmd_free = 1; cmd_frame = fr;
    if (with_req) begin
      req_valid = 1; req_pid = 1; req_vaddr = 22'h1;
      #1 chk(req_ready == 0, "R10", "command priority", req_ready, 0);
    end
    @(posedge clk); @(negedge clk);
    cmd_valid = 0; req_valid = 0;
    chk(cmd_done && cmd_ok == exp, "R9", "free ok", cmd_ok, exp);
    chk(cmd_slot == fr, "R9", "free slot", cmd_slot, fr);
    m_v[fr] = 0;
    @(negedge clk);
  endtask

  initial begin
    #50000;
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_p[i] = 0; m_n[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && cmd_ready && !resp_valid && !cmd_done, "R1", "reset state",
        {req_ready, cmd_ready, resp_valid, cmd_done}, 4'b1100);
    lookup(6'd1, 10'h2A, 12'h123);               // R1 empty table miss, one probe
    insert(6'd2, 10'h013, "R4");                 // home 3^2 = 1
    lookup(6'd2, 10'h013, 12'hABC);              // R3 hit frame 1, R2 offset
    lookup(6'd10, 10'h013, 12'h005);             // R11 pid differs, probes past to free
    insert(6'd0, 10'h007, "R12");                // home 7
    insert(6'd0, 10'h00F, "R5");                 // collides, wraps to 0
    lookup(6'd0, 10'h00F, 12'hFFF);              // R5 hit frame 0 after 2 probes
    free_frame(3'd7, 0);                          // R9
    lookup(6'd0, 10'h00F, 12'h010);              // R6 chain broken, miss
    free_frame(3'd7, 1);                          // R9 already free, R10 priority
    for (int k = 0; k < 6; k++) insert(6'd5, 10'(k * 9 + 3), "R12");
    insert(6'd7, 10'h155, "R7");                 // table full
    lookup(6'd9, 10'h3FF, 12'h777);              // R7 8-probe miss
    lookup(6'd5, 10'h003, 12'h042);              // hit in full table
    lookup(6'd5, 10'(5 * 9 + 3), 12'h0F0);
    lookup(6'd2, 10'h013, 12'h321);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule